// File: doc/BRIEF.md
# Trigger-Controlled Trace Capture Buffer

This block records up to eight values from a debug observation path, such as change-of-flow addresses or data bus values, into a small buffer. An external trigger unit decides which values matter. It does so through two trigger inputs, and a capture strobe qualifies each candidate value. Software picks a capture mode, arms the buffer, and lets a run proceed. It then reads the stored entries back through a simple read port, oldest entry first.

Capture only takes place while the buffer is armed. The arm bit clears itself when the eighth entry lands or when an end-style trace finishes. Software may also stop a run by hand before the buffer fills. In that case a leading zero entry is placed ahead of the oldest stored value. This keeps the readout offset the same as for a run that filled the buffer. A count output always shows how many entries the current run has stored.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the buffer is disarmed, the count is 0 and the read data output is 0.
- R2: A pulse on `arm_set` arms the buffer, latches `mode`, and clears the count and both pointers, all visible on the next cycle. When `arm_set` and `arm_clr` are high together, `arm_set` wins.
- R3: Begin mode (`mode` = 2'b00): storing starts with the strobe that coincides with a `trig_begin` pulse and continues for every later strobe.
- R4: End mode (`mode` = 2'b01): every strobe from arming onward is stored. The strobe that coincides with `trig_end` is stored, and the buffer then disarms on its own.
- R5: Data mode (`mode` = 2'b10 or 2'b11): a strobe is stored only in a cycle where `trig_begin` is also high.
- R6: The count rises by exactly one for each stored entry, one cycle after the strobe. When it reaches 8 (4'b1000, full) the buffer disarms.
- R7: While disarmed, strobes and triggers store nothing and the count holds.
- R8: Each `rd_en` pulse while disarmed puts the next entry on `rd_data` one cycle later, in the order the entries were stored.
- R9: A read while armed returns 0 on `rd_data` and does not advance the read position.
- R10: If `arm_clr` disarms the buffer before it is full, the contents shift by one position. The first read then returns 0 and the stored entries follow in order. A strobe in that same cycle is not stored.
- R11: `trig_end` has no effect in begin mode or data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set | input | 1 | Arm pulse; latches mode and clears the run state |
| arm_clr | input | 1 | Manual disarm pulse |
| mode | input | 2 | Capture mode: 00 begin, 01 end, 1x data |
| cap_valid | input | 1 | Capture strobe for `cap_value` |
| cap_value | input | WIDTH | Candidate address or data value |
| trig_begin | input | 1 | Begin trigger, or match qualifier in data mode |
| trig_end | input | 1 | End trigger (end mode only) |
| rd_en | input | 1 | Read request pulse |
| rd_data | output | WIDTH | Entry returned by the last read |
| armed | output | 1 | Buffer is armed |
| count | output | $clog2(DEPTH+1) | Number of entries stored in this run |

## Verification
The assertions check, on every cycle, several rules. An arm pulse always yields an armed, empty buffer. The count never exceeds full and only ever grows by one per cycle while armed. A full count always coincides with a disarmed buffer. A disarmed buffer never changes its count, and a read while armed always returns zero. Which strobes are selected in each mode, the oldest-first order of the readout, and the leading zero after a manual disarm depend on data values across whole runs. Only the bench's sweeps show these, over trigger positions and match patterns.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [1:0] {
        TCB_BEGIN = 2'b00,
        TCB_END   = 2'b01,
        TCB_DATA  = 2'b10
    } tcb_mode_e;

    function automatic logic is_data_mode(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/tcb_ctrl.sv
module tcb_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm_set,
    input  logic                         arm_clr,
    input  logic [1:0]                   mode_i,
    input  logic                         cap_valid,
    input  logic                         trig_begin,
    input  logic                         trig_end,
    input  logic                         rd_en,
    output logic                         armed_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         wr_en_o,
    output logic [$clog2(DEPTH)-1:0]     wr_addr_o,
    output logic                         pad_wr_o,
    output logic                         rd_fire_o,
    output logic                         rd_zero_o,
    output logic [$clog2(DEPTH)-1:0]     rd_addr_o
);
    import tcb_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] PAD_PTR  = AW'(DEPTH - 1);

    typedef struct packed {
        logic          armed;
        logic [1:0]    mode;
        logic          capturing;
        logic [CW-1:0] cnt;
        logic [AW-1:0] rdp;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  store;
    logic  active;

    always_comb begin
        st_d      = st_q;
        store     = 1'b0;
        active    = 1'b0;
        pad_wr_o  = 1'b0;
        rd_fire_o = 1'b0;
        rd_zero_o = 1'b0;

        if (rd_en) begin
            if (st_q.armed) begin
                rd_zero_o = 1'b1;
            end else begin
                rd_fire_o = 1'b1;
                st_d.rdp  = st_q.rdp + AW'(1);
            end
        end

        if (arm_set) begin
            st_d.armed     = 1'b1;
            st_d.mode      = mode_i;
            st_d.capturing = 1'b0;
            st_d.cnt       = '0;
            st_d.rdp       = '0;
        end else if (st_q.armed) begin
            if (arm_clr) begin
                st_d.armed     = 1'b0;
                st_d.capturing = 1'b0;
                st_d.rdp       = PAD_PTR;
                pad_wr_o       = 1'b1;
            end else begin
                if (is_data_mode(st_q.mode)) begin
                    active = trig_begin;
                end else if (st_q.mode == TCB_END) begin
                    active = 1'b1;
                end else begin
                    active = st_q.capturing | trig_begin;
                    if (trig_begin) begin
                        st_d.capturing = 1'b1;
                    end
                end
                store = cap_valid & active;
                if (store) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                    if (st_q.cnt + CW'(1) == FULL_CNT) begin
                        st_d.armed     = 1'b0;
                        st_d.capturing = 1'b0;
                    end
                end
                if ((st_q.mode == TCB_END) && trig_end) begin
                    st_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o   = st_q.armed;
    assign count_o   = st_q.cnt;
    assign wr_en_o   = store;
    assign wr_addr_o = st_q.cnt[AW-1:0];
    assign rd_addr_o = st_q.rdp;

endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     pad_wr,
    input  logic                     rd_fire,
    input  logic                     rd_zero,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [WIDTH-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (wr_en && (wr_addr == AW'(g))) begin
                ent_d = wr_data;
            end
            if (pad_wr && (g == DEPTH - 1)) begin
                ent_d = '0;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d;
            end
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_zero) begin
            rd_d = '0;
        end else if (rd_fire) begin
            rd_d = ent_q[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm_set,
    input  logic                       arm_clr,
    input  logic [1:0]                 mode,
    input  logic                       cap_valid,
    input  logic [WIDTH-1:0]           cap_value,
    input  logic                       trig_begin,
    input  logic                       trig_end,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       armed,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en, pad_wr, rd_fire, rd_zero;
    logic [AW-1:0] wr_addr, rd_addr;

    tcb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_set   (arm_set),
        .arm_clr   (arm_clr),
        .mode_i    (mode),
        .cap_valid (cap_valid),
        .trig_begin(trig_begin),
        .trig_end  (trig_end),
        .rd_en     (rd_en),
        .armed_o   (armed),
        .count_o   (count),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .pad_wr_o  (pad_wr),
        .rd_fire_o (rd_fire),
        .rd_zero_o (rd_zero),
        .rd_addr_o (rd_addr)
    );

    tcb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(cap_value),
        .pad_wr (pad_wr),
        .rd_fire(rd_fire),
        .rd_zero(rd_zero),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       arm_set,
    input logic                       rd_en,
    input logic [WIDTH-1:0]           rd_data,
    input logic                       armed,
    input logic [$clog2(DEPTH+1)-1:0] count
);
    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_set |=> (armed && count == 0));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH);

    p_full_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == DEPTH) |-> !armed);

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_set) |=> (count == $past(count) || count == $past(count) + 1));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_set) |=> $stable(count));

    p_armed_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && armed) |=> rd_data == '0);

endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_set(arm_set),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .armed  (armed),
    .count  (count)
);

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_set = 1'b0, arm_clr = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic             cap_valid = 1'b0;
    logic [WIDTH-1:0] cap_value = '0;
    logic             trig_begin = 1'b0, trig_end = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             armed;
    logic [3:0]       count;

    int checks = 0;
    int errors = 0;
    int exp_val [DEPTH];
    int exp_n;

    always #2.5 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
        .mode(mode), .cap_valid(cap_valid), .cap_value(cap_value),
        .trig_begin(trig_begin), .trig_end(trig_end), .rd_en(rd_en),
        .rd_data(rd_data), .armed(armed), .count(count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic arm_run(input logic [1:0] m, input logic with_clr);
        mode = m; arm_set = 1'b1; arm_clr = with_clr;
        @(negedge clk);
        arm_set = 1'b0; arm_clr = 1'b0;
        check("R2 armed", int'(armed), 1);
        check("R2 count", int'(count), 0);
    endtask

    task automatic step(input int v, input logic vld, input logic tb, input logic te);
        cap_value = WIDTH'(v); cap_valid = vld; trig_begin = tb; trig_end = te;
        @(negedge clk);
        cap_valid = 1'b0; trig_begin = 1'b0; trig_end = 1'b0;
    endtask

    task automatic read_expect(input string req, input int exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, int'(rd_data), exp);
    endtask

    task automatic finish_and_read(input string req);
        logic was_armed;
        check({req, " count"}, int'(count), exp_n);
        check({req, " R6 armed"}, int'(armed), (exp_n < DEPTH) ? 1 : 0);
        was_armed = armed;
        if (was_armed) begin
            arm_clr = 1'b1;
            cap_valid = 1'b1; cap_value = 16'hFFFF; trig_begin = 1'b1;
            @(negedge clk);
            arm_clr = 1'b0; cap_valid = 1'b0; trig_begin = 1'b0;
            check("R10 count after clear", int'(count), exp_n);
            read_expect("R10 leading zero", 0);
        end
        for (int i = 0; i < exp_n; i++) read_expect({req, " R8 order"}, exp_val[i]);
        step(16'h5555, 1'b1, 1'b1, 1'b1);
        check("R7 idle count", int'(count), exp_n);
        check("R7 idle armed", int'(armed), 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 armed", int'(armed), 0);
        check("R1 count", int'(count), 0);
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: arm_set wins over arm_clr
        arm_run(2'b01, 1'b1);
        step(0, 1'b0, 1'b0, 1'b1);

        // R3 / R11: begin mode, sweep trigger position
        for (int t = 0; t < 10; t++) begin
            arm_run(2'b00, 1'b0);
            exp_n = 0;
            for (int k = 0; k < 12; k++) begin
                int v = 16'h1000 + t * 16 + k;
                if (k >= t && exp_n < DEPTH) begin
                    exp_val[exp_n] = v; exp_n++;
                end
                step(v, 1'b1, k == t, k == t + 1);
            end
            finish_and_read("R3 R11 begin");
        end

        // R4 / R9: end mode, sweep end position
        for (int e = 0; e < 10; e++) begin
            arm_run(2'b01, 1'b0);
            read_expect("R9 armed read", 0);
            exp_n = 0;
            for (int k = 0; k < 10; k++) begin
                int v = 16'h2000 + e * 16 + k;
                if (k <= e && exp_n < DEPTH) begin
                    exp_val[exp_n] = v; exp_n++;
                end
                step(v, 1'b1, 1'b0, k == e);
            end
            check("R4 disarmed", int'(armed), 0);
            check("R4 count", int'(count), exp_n);
            for (int i = 0; i < exp_n; i++) read_expect("R4 R8 R9 order", exp_val[i]);
        end

        // R5 / R11: data mode, match pattern sweep
        for (int p = 0; p < 6; p++) begin
            logic [9:0] mask;
            case (p)
                0: mask = 10'h000;
                1: mask = 10'h3FF;
                2: mask = 10'h155;
                3: mask = 10'h2AA;
                4: mask = 10'h0F0;
                default: mask = 10'h201;
            endcase
            arm_run((p % 2 == 0) ? 2'b10 : 2'b11, 1'b0);
            exp_n = 0;
            for (int k = 0; k < 10; k++) begin
                int v = 16'h3000 + p * 16 + k;
                if (mask[k] && exp_n < DEPTH) begin
                    exp_val[exp_n] = v; exp_n++;
                end
                step(v, 1'b1, mask[k], 1'b1);
            end
            finish_and_read("R5 R11 data");
        end

        // R10: manual disarm in end mode with every partial fill
        for (int n = 0; n < DEPTH; n++) begin
            arm_run(2'b01, 1'b0);
            exp_n = 0;
            for (int k = 0; k < n; k++) begin
                exp_val[exp_n] = 16'h4000 + n * 16 + k; exp_n++;
                step(exp_val[k], 1'b1, 1'b0, 1'b0);
            end
            finish_and_read("R10 manual");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule